// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is the serial target side of a small measurement device. A host on a two-wire I2C bus reaches an 8-bit space of byte registers through it. The block watches the bus lines, which it brings into its own clock domain, detects START, repeated START and STOP, and answers to one fixed 7-bit device address. In a write transfer the first byte after the device address loads an address pointer, and the bytes that follow are handed to the register file one at a time. In a read transfer bytes are streamed out from the pointer onwards. The pointer advances after every byte moved in either direction and rolls over from FFh to 00h.

Some measurement values are 16 bits wide and are stored as two neighbouring bytes, high byte first. When the host reads such a high byte, the block also keeps the low byte that the register file offered in the same cycle. If the host goes on to read the low byte within the same transfer, it gets that kept copy. A new measurement arriving between the two bytes therefore cannot produce a torn value. The block never drives SDA high: it only pulls the line low, and this is shown as an output-enable. An active-low wake input holds all bus logic and the pointer in reset.

Top module: `i2c_regslave`

## Requirements
- R1: After `rst` is released, `sda_oe` is 0, `reg_we` is 0 and the pointer `reg_addr` is 00h.
- R2: The first byte after a START is taken MSB first. Its bits 7:1 are compared with DEV_ADDR (default 0110100b), and its bit 0 selects a read when it is 1. On a match the target acknowledges by setting `sda_oe` to 1 during the ninth clock.
- R3: On an address mismatch the target sends no acknowledge, drives nothing and writes nothing until the next START. The pointer keeps its value.
- R4: In a write, the second byte is acknowledged and loaded into the pointer. Each data byte after it is acknowledged and gives a single-cycle `reg_we` pulse, with `reg_waddr` set to the pointer and `reg_wdata` set to the byte. The pointer then increments. Any address is acknowledged, and the register file drops writes to addresses it does not accept.
- R5: After MAX_WR (default 8) data bytes in one write transfer, any further data byte is not acknowledged and gives no `reg_we` pulse.
- R6: A read starts at the current pointer value. A write transfer that carries only the address byte, followed by a repeated START, sets the pointer for the read that follows.
- R7: Read bytes are sent MSB first. Each bit is driven after a falling SCL edge so that it is stable at the next rising edge. A master ACK (0) starts the next byte. A master NACK (1) leaves SDA released until the next START or STOP.
- R8: During a read the pointer goes from FFh to 00h.
- R9: When a byte is read at an address where `reg_pair` is 1, the low byte `reg_rdata[7:0]` is kept. A read of the next address in the same transfer returns the kept byte, not the current register value. START and STOP discard the kept byte.
- R10: While `wake_n` is 0, `sda_oe` is 0 from the next clock on, no write is issued, and the pointer returns to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_n | input | 1 | Active-low sleep: when 0, holds bus logic and pointer in reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Pointer; register file returns the bytes at this address |
| reg_rdata | input | 16 | {byte at reg_addr, byte at reg_addr+1} |
| reg_pair | input | 1 | reg_addr is the high byte of a 16-bit register |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_waddr | output | 8 | Write address |
| reg_wdata | output | 8 | Write data |

## Verification
The hardest case to reach is a torn 16-bit read. The register value has to change in the short window after the high byte has been loaded and before the low byte is fetched, and that window is set only by the bus timing. The bench breaks its byte read into the eight data bits and the acknowledge bit. It changes the low register byte between the two, so the change lands after the high byte was fetched but before the falling edge that fetches the low byte. It then starts a fresh transfer at the low byte to show that the kept copy is gone.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_DEV, RX_MEM, RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_in};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_in};
      scl_d    <= scl_pipe[TOP];
      sda_d    <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_val   = sda_s;
endmodule

// File: rtl/i2c_pair_hold.sv
module i2c_pair_hold #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hold_data
);
  logic          valid;
  logic [AW-1:0] held_addr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid     <= 1'b0;
      held_addr <= '0;
      hold_data <= '0;
    end else if (cap_en) begin
      valid     <= 1'b1;
      held_addr <= cap_addr;
      hold_data <= cap_data;
    end
  end

  assign hit = valid && (held_addr == look_addr);
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0110100,
  parameter int         MAX_WR      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  input  logic [2*BYTE_W-1:0] reg_rdata,
  input  logic              reg_pair,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata
);
  localparam int WCW = $clog2(MAX_WR + 1);

  logic bus_rst;
  logic scl_rise, scl_fall, start_det, stop_det, sda_val;

  bus_state_e        state;
  rx_kind_e          kind, ack_kind;
  logic [2:0]        bit_cnt;
  logic              rx_full, ack_tx, mack_nack;
  logic [BYTE_W-1:0] shreg, txreg, addr_q;
  logic [WCW-1:0]    wr_cnt;

  logic              load_now, hold_hit, cap_en;
  logic [BYTE_W-1:0] hold_data, rd_byte;

  assign bus_rst = rst | ~wake_n; // R10: sleep resets bus logic

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(bus_rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_val(sda_val)
  );

  // R9: byte fetch for read, with coherent low-byte hold
  assign load_now = scl_fall && (((state == ST_ACK) && ack_tx) ||
                                 ((state == ST_MACK) && !mack_nack));
  assign rd_byte  = hold_hit ? hold_data : reg_rdata[2*BYTE_W-1:BYTE_W];
  assign cap_en   = load_now && reg_pair && !hold_hit;

  i2c_pair_hold #(.AW(BYTE_W), .DW(BYTE_W)) u_hold (
    .clk(clk), .rst(bus_rst), .clr(start_det | stop_det),
    .cap_en(cap_en), .cap_addr(addr_q + BYTE_W'(1)),
    .cap_data(reg_rdata[BYTE_W-1:0]), .look_addr(addr_q),
    .hit(hold_hit), .hold_data(hold_data)
  );

  assign reg_addr = addr_q;

  always_ff @(posedge clk) begin
    if (bus_rst) begin
      state     <= ST_IDLE;
      kind      <= RX_DEV;
      ack_kind  <= RX_DEV;
      bit_cnt   <= '0;
      rx_full   <= 1'b0;
      ack_tx    <= 1'b0;
      mack_nack <= 1'b0;
      shreg     <= '0;
      txreg     <= '0;
      addr_q    <= '0;
      wr_cnt    <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= RX_DEV;
        bit_cnt <= '0;
        rx_full <= 1'b0;
        wr_cnt  <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && !rx_full) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_val};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              bit_cnt <= '0;
              case (kind)
                RX_DEV: begin
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin // R2
                    sda_oe   <= 1'b1;
                    state    <= ST_ACK;
                    ack_tx   <= shreg[0];
                    ack_kind <= RX_MEM;
                  end else begin
                    state <= ST_IGNORE; // R3
                  end
                end
                RX_MEM: begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  addr_q   <= shreg;
                  ack_tx   <= 1'b0;
                  ack_kind <= RX_DATA;
                end
                default: begin
                  if (wr_cnt < WCW'(MAX_WR)) begin // R5
                    sda_oe    <= 1'b1;
                    state     <= ST_ACK;
                    reg_we    <= 1'b1;
                    reg_waddr <= addr_q;
                    reg_wdata <= shreg;
                    addr_q    <= addr_q + BYTE_W'(1);
                    wr_cnt    <= wr_cnt + WCW'(1);
                    ack_tx    <= 1'b0;
                    ack_kind  <= RX_DATA;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              kind <= ack_kind;
              if (ack_tx) begin
                state   <= ST_TX;
                txreg   <= {rd_byte[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~rd_byte[BYTE_W-1];
                bit_cnt <= '0;
                addr_q  <= addr_q + BYTE_W'(1); // R8: natural 8-bit roll
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                sda_oe <= ~txreg[BYTE_W-1];
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              end
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_nack <= sda_val;
            end else if (scl_fall) begin
              if (mack_nack) begin
                state <= ST_IGNORE; // R7
              end else begin
                state   <= ST_TX;
                txreg   <= {rd_byte[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~rd_byte[BYTE_W-1];
                bit_cnt <= '0;
                addr_q  <= addr_q + BYTE_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic clk,
  input logic rst,
  input logic wake_n,
  input logic scl_in,
  input logic sda_oe,
  input logic reg_we
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we); // R4

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wake_n |=> (!sda_oe && !reg_we)); // R10

  AST_OE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (wake_n && $past(wake_n) && !$stable(sda_oe)) |-> !scl_in); // R7

  AST_WR_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_in); // R4
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst(rst), .wake_n(wake_n), .scl_in(scl_in),
  .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam int CLK_NS = 10;
  localparam int H      = 16;

  logic clk = 1'b0, rst = 1'b1, wake_n = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe, reg_pair, reg_we;
  logic [7:0]  reg_addr, reg_waddr, reg_wdata;
  logic [15:0] reg_rdata;

  int tests = 0, fails = 0, mon_tests = 0, mon_fails = 0, quiet_hits = 0;
  logic quiet = 1'b0;
  logic poke_en = 1'b0;
  logic [7:0] poke_addr = '0, poke_val = '0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_wq [$];

  always #(CLK_NS/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regslave uut (
    .clk(clk), .rst(rst), .wake_n(wake_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .reg_pair(reg_pair), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // Register file model: pairs at 10h and 16h, writable only 10h and 11h
  assign reg_rdata = {mem[reg_addr], mem[8'(reg_addr + 8'd1)]};
  assign reg_pair  = (reg_addr == 8'h10) || (reg_addr == 8'h16);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_we && (reg_waddr == 8'h10 || reg_waddr == 8'h11)) mem[reg_waddr] <= reg_wdata;
      if (poke_en) mem[poke_addr] <= poke_val;
    end
  end

  // Per-clock monitor: write strobes against the expected queue, quiet windows
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      mon_tests++;
      if (exp_wq.size() == 0) begin
        mon_fails++;
        $display("FAIL R4/R5 unexpected write actual=%h_%h expected=none", reg_waddr, reg_wdata);
      end else begin
        logic [15:0] e;
        e = exp_wq.pop_front();
        if ({reg_waddr, reg_wdata} !== e) begin
          mon_fails++;
          $display("FAIL R4 write actual=%h expected=%h", {reg_waddr, reg_wdata}, e);
        end
      end
    end
    if (quiet && sda_oe) quiet_hits++;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H); scl = 1'b1; wclk(H); sda_m = 1'b0; wclk(H); scl = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H); scl = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; wclk(H); scl = 1'b1; wclk(H); scl = 1'b0; wclk(4);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wclk(H); scl = 1'b1; wclk(H/2); b = sda_line; wclk(H/2); scl = 1'b0; wclk(4);
  endtask

  task automatic wbyte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack);
  endtask

  task automatic rbits(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
  endtask

  task automatic set_ptr(logic [7:0] a, string tag);
    logic ack;
    bus_start(); wbyte(8'h68, ack); chk({tag, " dev ack"}, 16'(ack), 16'd0);
    wbyte(a, ack); chk({tag, " mem ack"}, 16'(ack), 16'd0);
    bus_start(); wbyte(8'h69, ack); chk({tag, " rd ack"}, 16'(ack), 16'd0);
  endtask

  logic ack_b;
  logic [7:0] d;

  initial begin : watchdog
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    wclk(5); rst = 1'b0; wclk(3);
    chk("R1 sda_oe", 16'(sda_oe), 16'd0);
    chk("R1 reg_we", 16'(reg_we), 16'd0);
    chk("R1 pointer", 16'(reg_addr), 16'd0);

    // R2/R4: write two bytes at 10h
    bus_start();
    wbyte(8'h68, ack_b); chk("R2 address ack", 16'(ack_b), 16'd0);
    wbyte(8'h10, ack_b); chk("R4 mem ack", 16'(ack_b), 16'd0);
    exp_wq.push_back({8'h10, 8'hA5}); wbyte(8'hA5, ack_b); chk("R4 data ack 1", 16'(ack_b), 16'd0);
    exp_wq.push_back({8'h11, 8'h3C}); wbyte(8'h3C, ack_b); chk("R4 data ack 2", 16'(ack_b), 16'd0);
    bus_stop();
    exp_mem[8'h10] = 8'hA5; exp_mem[8'h11] = 8'h3C;

    // R6/R7: dummy write + repeated START, two-byte read, NACK release
    set_ptr(8'h10, "R6");
    rbits(d); chk("R6 read 10h", 16'(d), 16'(exp_mem[8'h10])); bit_out(1'b0);
    rbits(d); chk("R7 read 11h", 16'(d), 16'(exp_mem[8'h11]));
    quiet_hits = 0; quiet = 1'b1;
    bit_out(1'b1); wclk(2 * H);
    quiet = 1'b0; chk("R7 release after NACK", 16'(quiet_hits), 16'd0);
    bus_stop();

    // R6: current-pointer read continues at 12h
    bus_start(); wbyte(8'h69, ack_b); chk("R6 cur rd ack", 16'(ack_b), 16'd0);
    rbits(d); chk("R6 current read 12h", 16'(d), 16'(exp_mem[8'h12])); bit_out(1'b1);
    bus_stop();

    // R3: wrong device address, traffic ignored, pointer kept (13h)
    quiet_hits = 0; quiet = 1'b1;
    bus_start();
    wbyte(8'h6A, ack_b); chk("R3 no ack address", 16'(ack_b), 16'd1);
    wbyte(8'h40, ack_b); chk("R3 no ack byte", 16'(ack_b), 16'd1);
    wbyte(8'h77, ack_b); chk("R3 no ack data", 16'(ack_b), 16'd1);
    bus_stop();
    quiet = 1'b0; chk("R3 never drove", 16'(quiet_hits), 16'd0);
    bus_start(); wbyte(8'h69, ack_b);
    rbits(d); chk("R3 pointer kept", 16'(d), 16'(exp_mem[8'h13])); bit_out(1'b1);
    bus_stop();

    // R9: coherent pair read across an update of the low byte
    set_ptr(8'h16, "R9");
    rbits(d); chk("R9 high byte", 16'(d), 16'(exp_mem[8'h16]));
    poke_addr = 8'h17; poke_val = 8'hE7; poke_en = 1'b1; wclk(1); poke_en = 1'b0;
    bit_out(1'b0);
    rbits(d); chk("R9 held low byte", 16'(d), 16'(exp_mem[8'h17])); bit_out(1'b1);
    bus_stop();
    exp_mem[8'h17] = 8'hE7;
    set_ptr(8'h17, "R9b");
    rbits(d); chk("R9 hold cleared", 16'(d), 16'(exp_mem[8'h17])); bit_out(1'b1);
    bus_stop();

    // R8: rollover FFh -> 00h
    set_ptr(8'hFF, "R8");
    rbits(d); chk("R8 read FFh", 16'(d), 16'(exp_mem[8'hFF])); bit_out(1'b0);
    rbits(d); chk("R8 read 00h", 16'(d), 16'(exp_mem[8'h00])); bit_out(1'b1);
    bus_stop();

    // R5: write limit
    bus_start(); wbyte(8'h68, ack_b); wbyte(8'h20, ack_b);
    for (int i = 0; i < 8; i++) begin
      exp_wq.push_back({8'(8'h20 + i), 8'(8'h90 + i)});
      wbyte(8'(8'h90 + i), ack_b); chk("R5 data within limit acked", 16'(ack_b), 16'd0);
    end
    wbyte(8'hEE, ack_b); chk("R5 ninth byte not acked", 16'(ack_b), 16'd1);
    bus_stop();
    wclk(4); chk("R4/R5 all writes seen", 16'(exp_wq.size()), 16'd0);

    // R10: sleep during an acknowledge
    bus_start();
    for (int i = 7; i >= 0; i--) bit_out(8'h68 >> i);
    sda_m = 1'b1; wclk(H);
    chk("R10 driving ack before sleep", 16'(sda_oe), 16'd1);
    wake_n = 1'b0; wclk(2);
    chk("R10 released in sleep", 16'(sda_oe), 16'd0);
    chk("R10 pointer reset", 16'(reg_addr), 16'd0);
    wclk(H); wake_n = 1'b1; wclk(H);
    bus_stop();
    bus_start(); wbyte(8'h69, ack_b); chk("R10 ack after wake", 16'(ack_b), 16'd0);
    rbits(d); chk("R10 read from 00h", 16'(d), 16'(exp_mem[8'h00])); bit_out(1'b1);
    bus_stop();

    wclk(10);
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end
endmodule